// File: doc/BRIEF.md
# Reset-Time Configuration Image Loader

This block runs once after every hardware reset and needs no host command to do so. It reads a fixed 18-word (36-byte) configuration image from an external memory through a simple word request/acknowledge port. It then checks the image with an 8-bit modular checksum. If the image is good, the block fills a 16-byte shadow window and five 16-bit configuration registers from the image in one step. If the image is bad, or the memory stops answering, every register keeps its reset default and the block raises a relocatable-mode flag. Host software can then place the device by other means.

Each image word carries two bytes. The low byte is the even byte address and the high byte is the odd byte address. Words 0 to 7 make up the 16-byte window that the host reads at offsets 0 to 15. This window holds the station address, a driver interrupt byte, a hardware ID, user bytes, a stored 16-bit checksum and signature bytes. Words 8 to 12 feed, in order, the lower I/O base, the upper I/O base, the burst/bus control, the miscellaneous configuration and the interrupt control registers. The remaining words count only toward the checksum. Word 15 carries the adjust byte in its high half.

Host reads of the window are served from the on-chip copies and never reach the memory. A second, 16-bit checksum over part of the window is compared with the stored checksum. Its result is reported for information only and does not decide whether the image is accepted.

Top module: `cfg_autoload`

## Requirements
- R1: Reset state and start. While reset is held, busy is 1, load_done, load_valid and reloc_mode are 0, mem_req is 0, host_rdata is 00h and the configuration outputs hold their defaults. Within a few cycles of reset release, mem_req rises with mem_addr = 0, with no other input needed.
- R2: Word order. Exactly 18 words are requested, at word addresses 0 to 17 in ascending order. The address is held until mem_ack is seen. Each mem_ack accepts mem_rdata for the current address. No request is made after the last word.
- R3: Window bytes. Host offset n (0 to 15) returns the low byte of word n/2 when n is even and the high byte when n is odd.
- R4: Configuration words. Words 8, 9, 10, 11 and 12 load, as full 16-bit words, cfg_iobase_lo, cfg_iobase_hi, cfg_burst, cfg_misc and cfg_irqctl respectively.
- R5: Acceptance. The image is accepted exactly when the 8-bit modular sum of all 36 bytes equals FFh. On acceptance, load_done = load_valid = 1, reloc_mode = 0 and busy = 0.
- R6: Checksum failure. load_done = load_valid = 0 and reloc_mode = 1. Every configuration output keeps its default and every window byte reads 00h.
- R7: Secondary checksum. csum16_match is 1 when the 16-bit modular sum of bytes 00h–0Bh and 0Eh–0Fh equals the word {byte 0Dh, byte 0Ch}. It is reported once all 18 words have arrived, whether or not the image is accepted, and it never changes acceptance. csum16_match is 0 after a timeout.
- R8: Timeout. Counting the first cycle a request is presented as cycle 0, an acknowledge in cycle timeout_limit or earlier is accepted. A request with no acknowledge by then ends the load with the R6 fallback and drops mem_req.
- R9: Busy window. busy stays 1 from reset until the load ends. While busy is 1, host_rdata is 00h. Host reads never raise mem_req.
- R10: Atomic commit. The configuration outputs hold their defaults for the whole load. In the first cycle that busy is 0, all flags, window bytes and configuration outputs already have their final values.
- R11: Stability. Once busy is 0, all outputs other than host_rdata's address dependence stay constant until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| timeout_limit | input | TMO_W | Last request cycle in which an acknowledge is still accepted |
| mem_req | output | 1 | Word read request to the configuration memory |
| mem_addr | output | ADDR_W | Word address of the current request |
| mem_ack | input | 1 | Memory acknowledge; mem_rdata is valid with it |
| mem_rdata | input | 16 | Word returned by the memory |
| host_addr | input | 4 | Host read offset within the 16-byte window |
| host_rdata | output | 8 | Window byte at host_addr (00h while busy) |
| cfg_iobase_lo | output | 16 | Lower I/O base register |
| cfg_iobase_hi | output | 16 | Upper I/O base register |
| cfg_burst | output | 16 | Burst and bus control register |
| cfg_misc | output | 16 | Miscellaneous configuration register |
| cfg_irqctl | output | 16 | Interrupt control register |
| busy | output | 1 | Load in progress |
| load_done | output | 1 | Image read and accepted |
| load_valid | output | 1 | Image contents valid |
| reloc_mode | output | 1 | Load failed; defaults in force |
| csum16_match | output | 1 | Informational 16-bit checksum match |

## Verification
The assertions check the memory-port discipline on every cycle: the address is held while a request waits, it steps by one on each acknowledge, and no request appears outside the busy window. They also check the outputs on every cycle: the window reads zero and the registers hold their defaults while busy, the flag combinations stay consistent, and every result freezes once busy falls. Only the bench scenarios can show that specific bytes reach the right window offsets and registers, and that the 8-bit sum decides acceptance while the 16-bit match does not. The scenarios also cover the exact timeout boundary and the fallback after a stall part-way through the image.

// File: rtl/cfg_autoload_pkg.sv
package cfg_autoload_pkg;
  localparam int WORD_W       = 16;
  localparam int BYTE_W       = 8;
  localparam int SHADOW_WORDS = 8;
  localparam int SHADOW_BYTES = 2 * SHADOW_WORDS;
  localparam int CSUM_WORD    = 6;
  localparam int CFG_FIRST    = 8;
  localparam int CFG_REGS     = 5;
  localparam int STAGE_WORDS  = CFG_FIRST + CFG_REGS;
  localparam logic [BYTE_W-1:0] SUM_TARGET = 8'hFF;

  typedef enum logic [1:0] {
    SQ_START,
    SQ_FETCH,
    SQ_CHECK,
    SQ_DONE
  } seq_state_e;
endpackage

// File: rtl/cfg_fetch_seq.sv
module cfg_fetch_seq
  import cfg_autoload_pkg::*;
#(
  parameter int IMG_WORDS = 18,
  parameter int TMO_W     = 16,
  localparam int ADDR_W   = $clog2(IMG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMO_W-1:0]  timeout_limit,
  input  logic              mem_ack,
  input  logic              sum_ok,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              word_we,
  output logic [ADDR_W-1:0] word_idx,
  output logic              image_end,
  output logic              commit,
  output logic              fail
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(IMG_WORDS - 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [TMO_W-1:0]  tmo_q, tmo_d;
  logic              idx_en, tmo_en;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    tmo_d     = tmo_q;
    idx_en    = 1'b0;
    tmo_en    = 1'b0;
    word_we   = 1'b0;
    image_end = 1'b0;
    commit    = 1'b0;
    fail      = 1'b0;
    unique case (state_q)
      SQ_START: begin
        state_d = SQ_FETCH;
        idx_d   = '0;
        tmo_d   = '0;
        idx_en  = 1'b1;
        tmo_en  = 1'b1;
      end
      SQ_FETCH: begin
        if (mem_ack) begin
          word_we = 1'b1;
          tmo_d   = '0;
          tmo_en  = 1'b1;
          if (idx_q == LAST_IDX) begin
            state_d = SQ_CHECK;
          end else begin
            idx_d  = idx_q + 1'b1;
            idx_en = 1'b1;
          end
        end else if (tmo_q >= timeout_limit) begin
          fail    = 1'b1;
          state_d = SQ_DONE;
        end else begin
          tmo_d  = tmo_q + 1'b1;
          tmo_en = 1'b1;
        end
      end
      SQ_CHECK: begin
        image_end = 1'b1;
        commit    = sum_ok;
        fail      = !sum_ok;
        state_d   = SQ_DONE;
      end
      default: state_d = SQ_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_START;
      idx_q   <= '0;
      tmo_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
      if (tmo_en) tmo_q <= tmo_d;
    end
  end

  assign mem_req  = (state_q == SQ_FETCH);
  assign mem_addr = idx_q;
  assign word_idx = idx_q;
endmodule

// File: rtl/cfg_sum_acc.sv
module cfg_sum_acc
  import cfg_autoload_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_we,
  input  logic [ADDR_W-1:0] word_idx,
  input  logic [WORD_W-1:0] word_data,
  output logic              sum_ok,
  output logic              csum16_ok
);
  logic [BYTE_W-1:0] sum8_q, sum8_d;
  logic [WORD_W-1:0] sum16_q, sum16_d;
  logic [WORD_W-1:0] stored_q;
  logic [BYTE_W-1:0] lo_b, hi_b;
  logic              in_window, is_stored;

  assign lo_b      = word_data[BYTE_W-1:0];
  assign hi_b      = word_data[WORD_W-1:BYTE_W];
  assign is_stored = (word_idx == ADDR_W'(CSUM_WORD));
  assign in_window = (word_idx < ADDR_W'(SHADOW_WORDS)) && !is_stored;

  always_comb begin
    sum8_d  = sum8_q + lo_b + hi_b;
    sum16_d = sum16_q + {{(WORD_W-BYTE_W){1'b0}}, lo_b}
                      + {{(WORD_W-BYTE_W){1'b0}}, hi_b};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum8_q   <= '0;
      sum16_q  <= '0;
      stored_q <= '0;
    end else begin
      if (word_we) sum8_q <= sum8_d;
      if (word_we && in_window) sum16_q <= sum16_d;
      if (word_we && is_stored) stored_q <= word_data;
    end
  end

  assign sum_ok    = (sum8_q == SUM_TARGET);
  assign csum16_ok = (sum16_q == stored_q);
endmodule

// File: rtl/cfg_commit_regs.sv
module cfg_commit_regs
  import cfg_autoload_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [CFG_REGS*WORD_W-1:0] CFG_DEFAULTS = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       word_we,
  input  logic [ADDR_W-1:0]          word_idx,
  input  logic [WORD_W-1:0]          word_data,
  input  logic                       commit,
  input  logic                       fail,
  input  logic                       image_end,
  input  logic                       csum16_ok,
  input  logic [3:0]                 host_addr,
  output logic [CFG_REGS*WORD_W-1:0] cfg_flat,
  output logic [BYTE_W-1:0]          host_rdata,
  output logic                       busy,
  output logic                       load_done,
  output logic                       load_valid,
  output logic                       reloc_mode,
  output logic                       csum16_match
);
  logic [BYTE_W-1:0] shadow_w [SHADOW_BYTES];

  for (genvar g = 0; g < STAGE_WORDS; g++) begin : g_stage
    logic [WORD_W-1:0] word_q;
    logic              wr_en;
    assign wr_en = word_we && (word_idx == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en) word_q <= word_data;
    end
  end

  for (genvar b = 0; b < SHADOW_BYTES; b++) begin : g_shadow
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      byte_q <= '0;
      else if (commit) byte_q <= g_stage[b/2].word_q[(b%2)*BYTE_W +: BYTE_W];
    end
    assign shadow_w[b] = byte_q;
  end

  for (genvar j = 0; j < CFG_REGS; j++) begin : g_cfg
    logic [WORD_W-1:0] reg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_q <= CFG_DEFAULTS[j*WORD_W +: WORD_W];
      else if (commit) reg_q <= g_stage[CFG_FIRST+j].word_q;
    end
    assign cfg_flat[j*WORD_W +: WORD_W] = reg_q;
  end

  logic busy_q, busy_d, done_q, done_d, reloc_q, reloc_d, m16_q, m16_d;

  always_comb begin
    busy_d  = busy_q && !(commit || fail);
    done_d  = done_q || commit;
    reloc_d = reloc_q || fail;
    m16_d   = image_end ? csum16_ok : m16_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      reloc_q <= 1'b0;
      m16_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      reloc_q <= reloc_d;
      m16_q   <= m16_d;
    end
  end

  assign host_rdata   = busy_q ? '0 : shadow_w[host_addr];
  assign busy         = busy_q;
  assign load_done    = done_q;
  assign load_valid   = done_q;
  assign reloc_mode   = reloc_q;
  assign csum16_match = m16_q;
endmodule

// File: rtl/cfg_autoload.sv
module cfg_autoload
  import cfg_autoload_pkg::*;
#(
  parameter int IMG_WORDS = 18,
  parameter int TMO_W     = 16,
  parameter logic [CFG_REGS*WORD_W-1:0] CFG_DEFAULTS =
    {16'h0000, 16'h0002, 16'h9001, 16'h0000, 16'h0300},
  localparam int ADDR_W   = $clog2(IMG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMO_W-1:0]  timeout_limit,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  input  logic [3:0]        host_addr,
  output logic [7:0]        host_rdata,
  output logic [15:0]       cfg_iobase_lo,
  output logic [15:0]       cfg_iobase_hi,
  output logic [15:0]       cfg_burst,
  output logic [15:0]       cfg_misc,
  output logic [15:0]       cfg_irqctl,
  output logic              busy,
  output logic              load_done,
  output logic              load_valid,
  output logic              reloc_mode,
  output logic              csum16_match
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic              word_we, image_end, commit, fail, sum_ok, csum16_ok;
  logic [ADDR_W-1:0] word_idx;
  logic [CFG_REGS*WORD_W-1:0] cfg_flat;

  cfg_fetch_seq #(.IMG_WORDS(IMG_WORDS), .TMO_W(TMO_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_q), .timeout_limit(timeout_limit),
    .mem_ack(mem_ack), .sum_ok(sum_ok), .mem_req(mem_req), .mem_addr(mem_addr),
    .word_we(word_we), .word_idx(word_idx), .image_end(image_end),
    .commit(commit), .fail(fail)
  );

  cfg_sum_acc #(.ADDR_W(ADDR_W)) u_sum (
    .clk(clk), .rst_n(rst_sync_q), .word_we(word_we), .word_idx(word_idx),
    .word_data(mem_rdata), .sum_ok(sum_ok), .csum16_ok(csum16_ok)
  );

  cfg_commit_regs #(.ADDR_W(ADDR_W), .CFG_DEFAULTS(CFG_DEFAULTS)) u_regs (
    .clk(clk), .rst_n(rst_sync_q), .word_we(word_we), .word_idx(word_idx),
    .word_data(mem_rdata), .commit(commit), .fail(fail), .image_end(image_end),
    .csum16_ok(csum16_ok), .host_addr(host_addr), .cfg_flat(cfg_flat),
    .host_rdata(host_rdata), .busy(busy), .load_done(load_done),
    .load_valid(load_valid), .reloc_mode(reloc_mode), .csum16_match(csum16_match)
  );

  assign cfg_iobase_lo = cfg_flat[0*WORD_W +: WORD_W];
  assign cfg_iobase_hi = cfg_flat[1*WORD_W +: WORD_W];
  assign cfg_burst     = cfg_flat[2*WORD_W +: WORD_W];
  assign cfg_misc      = cfg_flat[3*WORD_W +: WORD_W];
  assign cfg_irqctl    = cfg_flat[4*WORD_W +: WORD_W];
endmodule

// File: rtl/cfg_autoload_chk.sv
module cfg_autoload_chk #(
  parameter int IMG_WORDS = 18,
  parameter logic [79:0] CFG_DEFAULTS = '0,
  localparam int ADDR_W = $clog2(IMG_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic [7:0]        host_rdata,
  input logic [15:0]       cfg_iobase_lo,
  input logic [15:0]       cfg_iobase_hi,
  input logic [15:0]       cfg_burst,
  input logic [15:0]       cfg_misc,
  input logic [15:0]       cfg_irqctl,
  input logic              busy,
  input logic              load_done,
  input logic              load_valid,
  input logic              reloc_mode,
  input logic              csum16_match
);
  logic [79:0] cfg_all;
  assign cfg_all = {cfg_irqctl, cfg_misc, cfg_burst, cfg_iobase_hi, cfg_iobase_lo};

  // R9
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  // R9
  host_zero_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> host_rdata == 8'h00);
  // R10
  cfg_default_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cfg_all == CFG_DEFAULTS);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (!mem_req || $stable(mem_addr)));
  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (!mem_req || mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));
  // R2
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr < ADDR_W'(IMG_WORDS));
  // R5
  done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid == load_done);
  // R6
  reloc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reloc_mode |-> (!load_valid && !busy));
  // R11
  busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);
  // R11
  results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable({cfg_all, load_done, load_valid, reloc_mode, csum16_match}));
  // R9
  no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind cfg_autoload cfg_autoload_chk #(.IMG_WORDS(IMG_WORDS), .CFG_DEFAULTS(CFG_DEFAULTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .host_rdata(host_rdata), .cfg_iobase_lo(cfg_iobase_lo), .cfg_iobase_hi(cfg_iobase_hi),
  .cfg_burst(cfg_burst), .cfg_misc(cfg_misc), .cfg_irqctl(cfg_irqctl), .busy(busy),
  .load_done(load_done), .load_valid(load_valid), .reloc_mode(reloc_mode),
  .csum16_match(csum16_match)
);

// File: tb/cfg_autoload_bench.sv
module cfg_autoload_bench;
  localparam int IMGW = 18;
  localparam int TMOW = 16;
  localparam logic [79:0] DEFS = {16'h0000, 16'h0002, 16'h9001, 16'h0000, 16'h0300};

  logic clk, rst_n, mem_req, mem_ack;
  logic [TMOW-1:0] timeout_limit;
  logic [4:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [3:0] host_addr;
  logic [7:0] host_rdata;
  logic [15:0] cfg_iobase_lo, cfg_iobase_hi, cfg_burst, cfg_misc, cfg_irqctl;
  logic busy, load_done, load_valid, reloc_mode, csum16_match;

  cfg_autoload #(.IMG_WORDS(IMGW), .TMO_W(TMOW), .CFG_DEFAULTS(DEFS)) u_cfg_autoload (
    .clk(clk), .rst_n(rst_n), .timeout_limit(timeout_limit), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .host_addr(host_addr), .host_rdata(host_rdata), .cfg_iobase_lo(cfg_iobase_lo),
    .cfg_iobase_hi(cfg_iobase_hi), .cfg_burst(cfg_burst), .cfg_misc(cfg_misc),
    .cfg_irqctl(cfg_irqctl), .busy(busy), .load_done(load_done),
    .load_valid(load_valid), .reloc_mode(reloc_mode), .csum16_match(csum16_match)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [15:0] img [IMGW];
  int lat = 0, stall_at = -1, reqcyc = 0, log_n = 0;
  logic [4:0] log_a [64];

  // memory model: acknowledges in request cycle 'lat', never for word 'stall_at'
  initial begin
    mem_ack = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        if (int'(mem_addr) != stall_at && reqcyc == lat) begin
          mem_ack = 1'b1; mem_rdata = img[mem_addr];
          if (log_n < 64) log_a[log_n] = mem_addr;
          log_n++; reqcyc = 0;
        end else begin
          mem_ack = 1'b0; reqcyc++;
        end
      end else begin
        mem_ack = 1'b0; reqcyc = 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bt(input int b);
    return (b % 2) ? img[b/2][15:8] : img[b/2][7:0];
  endfunction

  function automatic logic [15:0] c16_calc();
    logic [15:0] s = '0;
    for (int b = 0; b < 16; b++) if (b != 12 && b != 13) s = s + 16'(bt(b));
    return s;
  endfunction

  task automatic make_image(input int seed, input bit good16, input bit good8);
    logic [7:0] s8;
    for (int w = 0; w < IMGW; w++) img[w] = {8'(seed * 5 + 7 * w + 3), 8'(seed + 11 * w + 1)};
    img[15] = 16'h0000;
    img[6] = good16 ? c16_calc() : (c16_calc() ^ 16'h00F0);
    s8 = '0;
    for (int b = 0; b < 36; b++) s8 = s8 + bt(b);
    img[15][15:8] = good8 ? (8'hFF - s8) : (8'hFF - s8 + 8'h01);
  endtask

  task automatic start_load(input int limit, input int l, input int st);
    rst_n = 1'b0; timeout_limit = TMOW'(limit); lat = l; stall_at = st;
    repeat (3) @(negedge clk);
    log_n = 0;
    rst_n = 1'b1;
  endtask

  // waits for busy to fall and checks the first idle cycle (R10)
  task automatic wait_idle(input bit exp_ok);
    int i;
    for (i = 0; i < 3000 && busy; i++) @(negedge clk);
    chk("R10", "busy fell", {31'd0, busy}, 32'd0);
    chk("R10", "valid at first idle cycle", {31'd0, load_valid}, {31'd0, exp_ok});
    chk("R10", "irqctl at first idle cycle", {16'd0, cfg_irqctl}, exp_ok ? {16'd0, img[12]} : {16'd0, DEFS[79:64]});
  endtask

  task automatic check_ok(input string tag);
    for (int n = 0; n < 16; n++) begin
      host_addr = 4'(n); #1;
      chk("R3", $sformatf("%s window byte %0d", tag, n), {24'd0, host_rdata}, {24'd0, bt(n)});
      @(negedge clk);
    end
    chk("R4", "iobase_lo", {16'd0, cfg_iobase_lo}, {16'd0, img[8]});
    chk("R4", "iobase_hi", {16'd0, cfg_iobase_hi}, {16'd0, img[9]});
    chk("R4", "burst", {16'd0, cfg_burst}, {16'd0, img[10]});
    chk("R4", "misc", {16'd0, cfg_misc}, {16'd0, img[11]});
    chk("R4", "irqctl", {16'd0, cfg_irqctl}, {16'd0, img[12]});
    chk("R5", "done/valid/reloc", {29'd0, load_done, load_valid, reloc_mode}, 32'b110);
    chk("R7", "csum16 match", {31'd0, csum16_match}, {31'd0, c16_calc() == img[6]});
    chk("R9", "no request after load", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic check_fail(input string req);
    chk(req, "done/valid/reloc", {29'd0, load_done, load_valid, reloc_mode}, 32'b001);
    chk(req, "cfg defaults", {cfg_irqctl, cfg_misc}, DEFS[79:48]);
    chk(req, "cfg defaults lo", {cfg_burst, cfg_iobase_hi}, DEFS[47:16]);
    chk(req, "cfg default base", {16'd0, cfg_iobase_lo}, {16'd0, DEFS[15:0]});
    for (int n = 0; n < 16; n++) begin
      host_addr = 4'(n); #1;
      chk(req, $sformatf("window byte %0d zero", n), {24'd0, host_rdata}, 32'd0);
      @(negedge clk);
    end
    chk(req, "request dropped", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_reset();
    bit seen;
    make_image(1, 1'b1, 1'b1);
    rst_n = 1'b0; timeout_limit = 16'd8; lat = 0; stall_at = -1; host_addr = 4'd0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", {31'd0, busy}, 32'd1);
    chk("R1", "flags in reset", {29'd0, load_done, load_valid, reloc_mode}, 32'd0);
    chk("R1", "no request in reset", {31'd0, mem_req}, 32'd0);
    chk("R1", "host read in reset", {24'd0, host_rdata}, 32'd0);
    chk("R1", "default iobase_lo", {16'd0, cfg_iobase_lo}, {16'd0, DEFS[15:0]});
    log_n = 0; rst_n = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 8 && !seen; i++) begin
      #1;
      if (mem_req) begin
        seen = 1'b1;
        chk("R1", "first address", {27'd0, mem_addr}, 32'd0);
      end else @(negedge clk);
    end
    chk("R1", "request started", {31'd0, seen}, 32'd1);
    wait_idle(1'b1);
    check_ok("reset");
  endtask

  task automatic t_good(input int seed, input int l, input bit good16);
    make_image(seed, good16, 1'b1);
    start_load(8, l, -1);
    repeat (12) @(negedge clk);
    host_addr = 4'd1; #1;
    chk("R9", "host read while busy", {24'd0, host_rdata}, 32'd0);
    chk("R10", "defaults while busy", {16'd0, cfg_misc}, {16'd0, DEFS[63:48]});
    wait_idle(1'b1);
    chk("R2", "word count", log_n, 32'd18);
    for (int i = 0; i < 18; i++) chk("R2", $sformatf("order %0d", i), {27'd0, log_a[i]}, i);
    check_ok(good16 ? "good16" : "bad16");
    repeat (10) @(negedge clk);
    chk("R11", "valid held", {29'd0, load_done, load_valid, reloc_mode}, 32'b110);
    chk("R11", "burst held", {16'd0, cfg_burst}, {16'd0, img[10]});
  endtask

  task automatic t_badsum();
    make_image(7, 1'b1, 1'b0);
    start_load(8, 1, -1);
    wait_idle(1'b0);
    chk("R2", "all words read", log_n, 32'd18);
    chk("R7", "match reported on reject", {31'd0, csum16_match}, 32'd1);
    check_fail("R6");
  endtask

  task automatic t_timeout();
    make_image(9, 1'b1, 1'b1);
    start_load(4, 0, 5);
    wait_idle(1'b0);
    chk("R8", "words before stall", log_n, 32'd5);
    chk("R7", "no match after timeout", {31'd0, csum16_match}, 32'd0);
    check_fail("R8");
  endtask

  task automatic t_tmo_edge();
    make_image(12, 1'b1, 1'b1);
    start_load(3, 3, -1);
    wait_idle(1'b1);
    chk("R8", "ack at limit accepted", {29'd0, load_done, load_valid, reloc_mode}, 32'b110);
    start_load(3, 4, -1);
    wait_idle(1'b0);
    chk("R8", "ack past limit rejected", {29'd0, load_done, load_valid, reloc_mode}, 32'b001);
    chk("R8", "no word taken", log_n, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_addr = '0; timeout_limit = 16'd8;
    t_reset();
    t_good(3, 0, 1'b1);
    t_good(5, 3, 1'b0);
    t_badsum();
    t_timeout();
    t_tmo_edge();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule